// File: doc/BRIEF.md
# Serial-Loaded Control Latch

This block holds a small control word that reaches it over three wires: a data line, a shift clock and a load strobe. A transmitter state machine takes a parallel value and a start request and plays the wire sequence out: for each bit, most significant first, it sets the data line while the shift clock is low, then raises the shift clock. After the last bit it returns both lines low, then pulses the load strobe high and low again, and finally raises a one-cycle done pulse. Each wire phase lasts a programmable number of system clocks.

The receiving side samples the three wires on the system clock through a synchroniser chain and finds rising edges itself. A rising shift-clock edge pushes the data line into a staging register. A rising load edge copies the staging register to the parallel outputs, so the outputs never show a half-shifted word. The transmitter's wires come out as ports and the receiver's wire inputs are separate ports, so the two can be tied together or used on their own.

Top module: `serial_ctrl_latch`

## Requirements
- R1: After reset, ctrl_q is 0, the three transmit wires are low, and busy and done are 0.
- R2: A start in idle sends exactly four shift-clock rising edges; the data line at the k-th rise (k = 0..3) equals value[3-k], so the most significant bit goes first.
- R3: While ser_clk is high the data line does not change; data only moves while the shift clock is low.
- R4: ser_load stays low during the shifting phase and is high only while ser_clk and ser_data are both low.
- R5: Every wire phase lasts phase_len+1 system clocks, phase_len being the value sampled at start; in particular each ser_clk high pulse and the ser_load pulse are phase_len+1 cycles wide.
- R6: done is a single-cycle pulse that follows the fall of ser_load, once per transfer; busy is high from the cycle after start until done, and low when done is high.
- R7: A start request while busy is ignored; the transfer in progress completes with its original value.
- R8: On a rising edge of rx_load, ctrl_q takes the last four bits shifted in on rx_clk rising edges, the first of them landing in bit 3.
- R9: ctrl_q does not change when rx_load has been low for the last four system clocks, however many shift-clock edges arrive.
- R10: When more than four bits are shifted before a load, only the last four are kept; a load with no new shifts presents the staged word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send `value` |
| value | input | 4 | Word to transmit |
| phase_len | input | 4 | Extra system clocks per wire phase (phase lasts phase_len+1) |
| busy | output | 1 | Transmitter is sending |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| ser_data | output | 1 | Transmit data line |
| ser_clk | output | 1 | Transmit shift clock |
| ser_load | output | 1 | Transmit load strobe |
| rx_data | input | 1 | Receive data line (asynchronous) |
| rx_clk | input | 1 | Receive shift clock (asynchronous) |
| rx_load | input | 1 | Receive load strobe (asynchronous) |
| ctrl_q | output | 4 | Latched parallel control outputs |

## Verification
With the transmit wires looped back to the receiver, every one of the sixteen values is sent at phase lengths 0, 1 and 3; the full value sweep separates a reversed bit order or a stuck bit, and the varied phase lengths separate a hold counter that miscounts or ignores its setting, while the wire monitors catch data moving under a high clock or a load that overlaps shifting. A second start during a transfer shows whether a busy request leaks through. With the loop opened, the bench drives the wires by hand: four shifts without a load tell whether the outputs follow the staging register, six shifts tell whether only the last four bits are kept, and a repeated bare load shows the staging word survives a transfer.

// File: rtl/sl_pkg.sv
package sl_pkg;

    localparam int SL_WORD_BITS = 4;

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_SETUP,
        DS_HIGH,
        DS_TAIL,
        DS_LDHI,
        DS_LDLO
    } drv_state_e;

    typedef struct packed {
        logic dat;
        logic sck;
        logic ld;
    } wire_bus_t;

    function automatic wire_bus_t mk_bus(input logic d, input logic c, input logic l);
        wire_bus_t b;
        b.dat = d;
        b.sck = c;
        b.ld  = l;
        return b;
    endfunction

endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain[0] <= async_in;
            prev     <= chain[STAGES-1];
        end
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= 1'b0;
                else     chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/sl_driver.sv
module sl_driver
    import sl_pkg::*;
#(
    parameter int NBITS = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NBITS-1:0] value,
    input  logic [CNT_W-1:0] phase_len,
    output wire_bus_t        bus,
    output logic             busy,
    output logic             done
);
    localparam int IDX_W = $clog2(NBITS + 1);

    drv_state_e       state;
    logic [CNT_W-1:0] hold_cnt;
    logic [CNT_W-1:0] hold_len;
    logic [NBITS-1:0] shreg;
    logic [IDX_W-1:0] bits_left;
    wire_bus_t        bus_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= DS_IDLE;
            hold_cnt  <= '0;
            hold_len  <= '0;
            shreg     <= '0;
            bits_left <= '0;
            bus_q     <= mk_bus(1'b0, 1'b0, 1'b0);
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state == DS_IDLE) begin
                if (start) begin
                    shreg     <= value;
                    hold_len  <= phase_len;
                    hold_cnt  <= phase_len;
                    bits_left <= IDX_W'(NBITS);
                    bus_q     <= mk_bus(value[NBITS-1], 1'b0, 1'b0);
                    state     <= DS_SETUP;
                end
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end else begin
                hold_cnt <= hold_len;
                case (state)
                    DS_SETUP: begin
                        bus_q <= mk_bus(shreg[NBITS-1], 1'b1, 1'b0);
                        state <= DS_HIGH;
                    end
                    DS_HIGH: begin
                        if (bits_left > IDX_W'(1)) begin
                            shreg     <= {shreg[NBITS-2:0], 1'b0};
                            bits_left <= bits_left - 1'b1;
                            bus_q     <= mk_bus(shreg[NBITS-2], 1'b0, 1'b0);
                            state     <= DS_SETUP;
                        end else begin
                            bus_q <= mk_bus(1'b0, 1'b0, 1'b0);
                            state <= DS_TAIL;
                        end
                    end
                    DS_TAIL: begin
                        bus_q <= mk_bus(1'b0, 1'b0, 1'b1);
                        state <= DS_LDHI;
                    end
                    DS_LDHI: begin
                        bus_q <= mk_bus(1'b0, 1'b0, 1'b0);
                        state <= DS_LDLO;
                    end
                    DS_LDLO: begin
                        state  <= DS_IDLE;
                        done_q <= 1'b1;
                    end
                    default: state <= DS_IDLE;
                endcase
            end
        end
    end

    assign bus  = bus_q;
    assign busy = (state != DS_IDLE);
    assign done = done_q;
endmodule

// File: rtl/sl_receiver.sv
module sl_receiver #(
    parameter int NBITS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dat_lvl,
    input  logic             sck_rise,
    input  logic             ld_rise,
    output logic [NBITS-1:0] q
);
    logic [NBITS-1:0] stage;
    logic [NBITS-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            out_q <= '0;
        end else begin
            if (sck_rise) stage <= {stage[NBITS-2:0], dat_lvl};
            if (ld_rise)  out_q <= stage;
        end
    end

    assign q = out_q;
endmodule

// File: rtl/serial_ctrl_latch.sv
module serial_ctrl_latch
    import sl_pkg::*;
#(
    parameter int NBITS       = SL_WORD_BITS,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NBITS-1:0] value,
    input  logic [CNT_W-1:0] phase_len,
    output logic             busy,
    output logic             done,
    output logic             ser_data,
    output logic             ser_clk,
    output logic             ser_load,
    input  logic             rx_data,
    input  logic             rx_clk,
    input  logic             rx_load,
    output logic [NBITS-1:0] ctrl_q
);
    localparam int NWIRES = 3;

    wire_bus_t         tx_bus;
    logic [NWIRES-1:0] raw_w;
    logic [NWIRES-1:0] lvl_w;
    logic [NWIRES-1:0] rise_w;

    sl_driver #(.NBITS(NBITS), .CNT_W(CNT_W)) u_drv (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .value     (value),
        .phase_len (phase_len),
        .bus       (tx_bus),
        .busy      (busy),
        .done      (done)
    );

    assign ser_data = tx_bus.dat;
    assign ser_clk  = tx_bus.sck;
    assign ser_load = tx_bus.ld;

    assign raw_w = {rx_data, rx_clk, rx_load};

    genvar w;
    generate
        for (w = 0; w < NWIRES; w++) begin : g_wire
            sl_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst      (rst),
                .async_in (raw_w[w]),
                .level    (lvl_w[w]),
                .rise     (rise_w[w])
            );
        end
    endgenerate

    sl_receiver #(.NBITS(NBITS)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .dat_lvl  (lvl_w[2]),
        .sck_rise (rise_w[1]),
        .ld_rise  (rise_w[0]),
        .q        (ctrl_q)
    );
endmodule

// File: rtl/serial_ctrl_latch_chk.sv
module serial_ctrl_latch_chk #(
    parameter int NBITS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             ser_data,
    input logic             ser_clk,
    input logic             ser_load,
    input logic             rx_load,
    input logic [NBITS-1:0] ctrl_q
);
    assert_load_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> (!ser_clk && !ser_data));

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_after_load_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_load) |-> busy);

    assert_q_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!rx_load && !$past(rx_load) && !$past(rx_load, 2) && !$past(rx_load, 3))
        |-> $stable(ctrl_q));
endmodule

bind serial_ctrl_latch serial_ctrl_latch_chk #(.NBITS(NBITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .ser_load (ser_load),
    .rx_load  (rx_load),
    .ctrl_q   (ctrl_q)
);

// File: tb/serial_ctrl_latch_test.sv
module serial_ctrl_latch_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] value = '0;
    logic [3:0] phase_len = '0;
    logic       busy, done, ser_data, ser_clk, ser_load;
    logic [3:0] ctrl_q;
    logic       manual = 1'b0;
    logic       m_data = 1'b0, m_clk = 1'b0, m_load = 1'b0;
    logic       rx_data, rx_clk, rx_load;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [3:0] cap;
    int         rise_cnt;
    int         done_cnt;
    int         hi_cnt;
    int         ld_cnt;
    logic       prev_clk, prev_data;

    assign rx_data = manual ? m_data : ser_data;
    assign rx_clk  = manual ? m_clk  : ser_clk;
    assign rx_load = manual ? m_load : ser_load;

    always #5 clk = ~clk;

    serial_ctrl_latch uut (
        .clk(clk), .rst(rst), .start(start), .value(value), .phase_len(phase_len),
        .busy(busy), .done(done), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_load(ser_load), .rx_data(rx_data), .rx_clk(rx_clk), .rx_load(rx_load),
        .ctrl_q(ctrl_q)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R2: capture data on every shift-clock rise
    always @(posedge ser_clk) begin
        cap      = {cap[2:0], ser_data};
        rise_cnt = rise_cnt + 1;
    end

    // Wire monitors sampled away from the active edge (R3, R4, R5, R6)
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (!rst) begin
            if (prev_clk && ser_clk && (ser_data != prev_data))
                chk(1'b0, "R3 data moved under high clock", ser_data, prev_data);
            if (ser_load && (ser_clk || ser_data))
                chk(1'b0, "R4 load overlaps shifting", {ser_clk, ser_data}, 0);
            if (ser_clk) hi_cnt = hi_cnt + 1;
            else if (hi_cnt != 0) begin
                chk(hi_cnt == phase_len + 1, "R5 clock high width", hi_cnt, phase_len + 1);
                hi_cnt = 0;
            end
            if (ser_load) ld_cnt = ld_cnt + 1;
            else if (ld_cnt != 0) begin
                chk(ld_cnt == phase_len + 1, "R5 load width", ld_cnt, phase_len + 1);
                ld_cnt = 0;
            end
            if (done) begin
                done_cnt = done_cnt + 1;
                chk(!busy, "R6 busy low at done", busy, 0);
            end
        end
        prev_clk  = ser_clk;
        prev_data = ser_data;
    end

    task automatic send(input logic [3:0] v, input logic [3:0] pl, input bit poke);
        int guard;
        @(negedge clk);
        value     = v;
        phase_len = pl;
        cap       = '0;
        rise_cnt  = 0;
        done_cnt  = 0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R6 busy after start", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            value = ~v;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        repeat (8) @(negedge clk);
        chk(rise_cnt == 4, "R2 shift clock rise count", rise_cnt, 4);
        chk(cap == v, "R2 MSB-first bit order", cap, v);
        chk(done_cnt == 1, "R6 one done per transfer", done_cnt, 1);
        chk(ctrl_q == v, poke ? "R7 busy start ignored" : "R8 loopback latch", ctrl_q, v);
    endtask

    task automatic wire_bit(input logic b);
        m_data = b;
        repeat (4) @(negedge clk);
        m_clk = 1'b1;
        repeat (4) @(negedge clk);
        m_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wire_load();
        m_data = 1'b0;
        m_load = 1'b1;
        repeat (4) @(negedge clk);
        m_load = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        cap = '0; rise_cnt = 0; done_cnt = 0; hi_cnt = 0; ld_cnt = 0;
        prev_clk = 1'b0; prev_data = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(ctrl_q == 4'd0, "R1 reset ctrl_q", ctrl_q, 0);
        chk({ser_data, ser_clk, ser_load} == 3'b000, "R1 reset wires",
            {ser_data, ser_clk, ser_load}, 0);
        chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);

        // R2 R5 R8: full value sweep at three phase lengths
        foreach (phase_len[i]) begin end
        for (int p = 0; p < 3; p++) begin
            for (int v = 0; v < 16; v++) begin
                send(4'(v), (p == 0) ? 4'd0 : (p == 1) ? 4'd1 : 4'd3, 1'b0);
            end
        end

        // R7: start during busy is ignored
        send(4'd5, 4'd2, 1'b1);
        send(4'd12, 4'd0, 1'b1);

        // Manual wire drive
        manual = 1'b1;
        repeat (4) @(negedge clk);
        // R9: four shifts without load leave ctrl_q alone
        wire_bit(1'b1); wire_bit(1'b0); wire_bit(1'b1); wire_bit(1'b0);
        chk(ctrl_q == 4'd12, "R9 outputs hold during shifting", ctrl_q, 12);
        wire_load();
        chk(ctrl_q == 4'b1010, "R8 manual latch 1010", ctrl_q, 10);
        // R10: six shifts keep the last four
        wire_bit(1'b1); wire_bit(1'b1); wire_bit(1'b0);
        wire_bit(1'b0); wire_bit(1'b1); wire_bit(1'b1);
        chk(ctrl_q == 4'b1010, "R9 hold across six shifts", ctrl_q, 10);
        wire_load();
        chk(ctrl_q == 4'b0011, "R10 last four bits kept", ctrl_q, 3);
        wire_load();
        chk(ctrl_q == 4'b0011, "R10 bare load repeats stage", ctrl_q, 3);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule